// File: doc/BRIEF.md
# Memory-Mapped Character Screen Controller

This block holds the character buffer of an 8-row by 16-column text screen and exposes it to an 8-bit processor through three bus addresses: a data port, a control port and a cursor port. The processor sets the cursor, then writes characters through the data port. Each write lands in the cell the cursor points at. A read of the data port returns the cell under the cursor and leaves the cursor where it is.

The control port holds three things. An auto-advance bit moves the cursor forward after every stored character. A blank command fills the whole buffer with spaces, one cell per clock. A character-set select bit is passed through to the display side. A separate read-only scan port lets a renderer fetch any cell by its packed row/column index. Video timing and pixel generation belong to the renderer and are not part of this block.

Top module: `text_screen`

## Requirements
- R1: After reset the cursor reads 0 and the control port reads 0x00, so auto-advance is off, no blank is running and character set 0 is selected. Buffer contents are not defined by reset.
- R2: A bus write to address 0 (data port) stores `bus_wdata` into the cell at the cursor. A read of address 0 returns the cell at the cursor, combinationally.
- R3: A bus write to address 2 (cursor port) loads `bus_wdata[6:0]` into the cursor. A read of address 2 returns {1'b0, cursor}. The cursor is packed as rrrcccc, with the row in bits 6:4 and the column in bits 3:0.
- R4: When control bit 0 (auto-advance) is 1, each accepted data-port write adds one to the cursor, and 127 wraps to 0. When the bit is 0, the cursor holds.
- R5: A read of the data port never changes the cursor.
- R6: A control write with bit 1 set, while no blank is running, writes 0x20 into all 128 cells, one cell per clock. Control bit 1 reads back as 1 until the last cell is written and as 0 after that.
- R7: While a blank is running, data-port writes are ignored: no cell is stored and the cursor does not advance.
- R8: Control bit 2 selects the character set. It reads back on control bit 2 and drives `charset_sel`. A control read returns {5'b0, charset, blank busy, auto-advance}.
- R9: `scan_char` always shows the cell addressed by `scan_addr` (rrrcccc packed), with no clock delay.
- R10: Address 3 reads as 0x00, and writes to it change neither the cursor, the control state nor any cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Port select: 0 data, 1 control, 2 cursor, 3 unused |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port, combinational |
| scan_addr | input | 7 | Renderer cell index, rrrcccc |
| scan_char | output | 8 | Character at `scan_addr` |
| charset_sel | output | 1 | Character-set select for the renderer |

## Verification
Some rules are checked by the embedded assertions on every cycle:
- the step-by-one cursor advance with its wrap;
- the cursor loading exactly the written value;
- the cursor holding during reads, idle cycles and blank-time data writes;
- the blank counter moving one cell per clock and ending after the last cell.

Other behaviour only the bench scenarios can show:
- that characters land in and come back from the right cells;
- that the whole buffer reads as spaces after a blank, seen through the scan port;
- that writes made during a blank leave no trace;
- that the unused address is inert.

// File: rtl/text_screen_pkg.sv
package text_screen_pkg;
  typedef enum logic [1:0] {
    PORT_DATA = 2'd0,
    PORT_CTRL = 2'd1,
    PORT_CURS = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  localparam int CTRL_ADV_BIT  = 0;
  localparam int CTRL_BLNK_BIT = 1;
  localparam int CTRL_CSET_BIT = 2;
endpackage

// File: rtl/text_screen_store.sv
module text_screen_store #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/text_screen_fill.sv
module text_screen_fill #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic          busy_nxt;
  logic [AW-1:0] idx_nxt;

  always_comb begin
    busy_nxt = busy;
    idx_nxt  = idx;
    if (busy) begin
      idx_nxt = idx + 1'b1;
      if (idx == LAST) busy_nxt = 1'b0;
    end else if (start) begin
      busy_nxt = 1'b1;
      idx_nxt  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else begin
      busy <= busy_nxt;
      idx  <= idx_nxt;
    end
  end

  // R6: the blank walks the cells one per clock
  a_r6_one_cell_per_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));
  // R6: the blank stops right after the last cell
  a_r6_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == LAST) |=> !busy);
  // R6: a new blank begins at cell 0
  a_r6_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> idx == '0);
endmodule

// File: rtl/text_screen.sv
module text_screen
  import text_screen_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 4,
  parameter int DW       = 8,
  parameter logic [7:0] BLANK_CHAR = 8'h20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    bus_addr,
  input  logic                          bus_wr,
  input  logic [DW-1:0]                 bus_wdata,
  output logic [DW-1:0]                 bus_rdata,
  input  logic [ROW_BITS+COL_BITS-1:0]  scan_addr,
  output logic [DW-1:0]                 scan_char,
  output logic                          charset_sel
);
  localparam int AW = ROW_BITS + COL_BITS;

  logic [AW-1:0] cursor, cursor_nxt;
  logic          adv_en, adv_en_nxt;
  logic          cset, cset_nxt;
  logic          fill_busy;
  logic [AW-1:0] fill_idx;
  logic          blank_start;
  logic          data_wr_ok;
  logic          ctrl_wr;
  logic          curs_wr;
  logic          st_we;
  logic [AW-1:0] st_waddr;
  logic [DW-1:0] st_wdata;
  logic [DW-1:0] cell_at_cursor;

  assign data_wr_ok  = bus_wr && (bus_addr == PORT_DATA) && !fill_busy;
  assign ctrl_wr     = bus_wr && (bus_addr == PORT_CTRL);
  assign curs_wr     = bus_wr && (bus_addr == PORT_CURS);
  assign blank_start = ctrl_wr && bus_wdata[CTRL_BLNK_BIT];

  text_screen_fill #(.AW(AW)) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .start (blank_start),
    .busy  (fill_busy),
    .idx   (fill_idx)
  );

  always_comb begin
    st_we    = fill_busy || data_wr_ok;
    st_waddr = fill_busy ? fill_idx : cursor;
    st_wdata = fill_busy ? DW'(BLANK_CHAR) : bus_wdata;
  end

  text_screen_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .we      (st_we),
    .waddr   (st_waddr),
    .wdata   (st_wdata),
    .raddr_a (cursor),
    .rdata_a (cell_at_cursor),
    .raddr_b (scan_addr),
    .rdata_b (scan_char)
  );

  // next state for cursor and control bits
  always_comb begin
    cursor_nxt = cursor;
    adv_en_nxt = adv_en;
    cset_nxt   = cset;
    if (curs_wr) begin
      cursor_nxt = bus_wdata[AW-1:0];
    end else if (data_wr_ok && adv_en) begin
      cursor_nxt = cursor + 1'b1;
    end
    if (ctrl_wr) begin
      adv_en_nxt = bus_wdata[CTRL_ADV_BIT];
      cset_nxt   = bus_wdata[CTRL_CSET_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cursor <= '0;
      adv_en <= 1'b0;
      cset   <= 1'b0;
    end else begin
      cursor <= cursor_nxt;
      adv_en <= adv_en_nxt;
      cset   <= cset_nxt;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      PORT_DATA: bus_rdata = cell_at_cursor;
      PORT_CTRL: begin
        bus_rdata[CTRL_ADV_BIT]  = adv_en;
        bus_rdata[CTRL_BLNK_BIT] = fill_busy;
        bus_rdata[CTRL_CSET_BIT] = cset;
      end
      PORT_CURS: bus_rdata[AW-1:0] = cursor;
      default:   bus_rdata = '0;
    endcase
  end

  assign charset_sel = cset;

  // R3: the cursor takes the written value
  a_r3_cursor_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PORT_CURS) |=> cursor == $past(bus_wdata[AW-1:0]));
  // R4: an accepted write with auto-advance on steps the cursor by one (wrapping)
  a_r4_advance_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PORT_DATA && !fill_busy && adv_en) |=>
      cursor == $past(cursor) + 1'b1);
  // R5, R10: with no write to the data or cursor port, the cursor holds
  a_r5_cursor_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr || bus_addr == PORT_CTRL || bus_addr == PORT_NONE) |=> $stable(cursor));
  // R7: a data write during a blank leaves the cursor unchanged
  a_r7_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PORT_DATA && fill_busy) |=> $stable(cursor));
  // R8: the select output follows the last control write
  a_r8_cset_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PORT_CTRL) |=> charset_sel == $past(bus_wdata[CTRL_CSET_BIT]));
endmodule

// File: tb/tb_text_screen.sv
module tb_text_screen;
  logic       clk;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [6:0] scan_addr;
  logic [7:0] scan_char;
  logic       charset_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  text_screen dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .scan_addr   (scan_addr),
    .scan_char   (scan_char),
    .charset_sel (charset_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: {is_read, addr[1:0], wdata[7:0], expected[7:0], req[3:0]}
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 2'd1, 8'h00, 8'h00, 4'd1},  // R1 control off
    {1'b0, 2'd2, 8'h05, 8'h00, 4'd3},  // R3 cursor := 5
    {1'b0, 2'd0, 8'h41, 8'h00, 4'd2},  // R2 store 'A' at 5
    {1'b1, 2'd0, 8'h00, 8'h41, 4'd2},  // R2 read back 'A'
    {1'b1, 2'd2, 8'h00, 8'h05, 4'd4},  // R4 no advance when off
    {1'b0, 2'd1, 8'h01, 8'h00, 4'd4},  // R4 advance on
    {1'b0, 2'd0, 8'h42, 8'h00, 4'd4},  // R4 'B' at 5, cursor -> 6
    {1'b1, 2'd2, 8'h00, 8'h06, 4'd4},  // R4 cursor advanced
    {1'b0, 2'd0, 8'h43, 8'h00, 4'd4},  // R4 'C' at 6, cursor -> 7
    {1'b0, 2'd2, 8'h06, 8'h00, 4'd3},  // R3 cursor := 6
    {1'b1, 2'd0, 8'h00, 8'h43, 4'd5},  // R5 read 'C'
    {1'b1, 2'd0, 8'h00, 8'h43, 4'd5},  // R5 read again, same cell
    {1'b1, 2'd2, 8'h00, 8'h06, 4'd5},  // R5 cursor untouched by reads
    {1'b0, 2'd2, 8'h05, 8'h00, 4'd3},  // R3 cursor := 5
    {1'b1, 2'd0, 8'h00, 8'h42, 4'd2},  // R2 'B' overwrote 'A'
    {1'b0, 2'd1, 8'h04, 8'h00, 4'd8},  // R8 charset 1, advance off
    {1'b1, 2'd1, 8'h00, 8'h04, 4'd8},  // R8 control reads back
    {1'b1, 2'd3, 8'h00, 8'h00, 4'd10}  // R10 unused address reads 0
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_wr = 1'b0;
    #2 d = bus_rdata;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int mism;
    rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00; scan_addr = 7'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    bus_read(2'd2, rd); check("R1 cursor after reset", rd, 8'h00);
    bus_read(2'd1, rd); check("R1 control after reset", rd, 8'h00);
    check("R1 charset_sel after reset", {7'b0, charset_sel}, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][22]) begin
        bus_read(VEC[i][21:20], rd);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rd, VEC[i][11:4]);
      end else begin
        bus_write(VEC[i][21:20], VEC[i][19:12]);
      end
    end
    check("R8 charset_sel output", {7'b0, charset_sel}, 8'h01);

    // R4: wrap from 127 to 0
    bus_write(2'd1, 8'h01);
    bus_write(2'd2, 8'h7F);
    bus_write(2'd0, 8'h5A);
    bus_read(2'd2, rd); check("R4 wrap 127 to 0", rd, 8'h00);

    // R9: scan port with packed row/col (row 1, col 5 = 0x15)
    bus_write(2'd2, 8'h15);
    bus_write(2'd0, 8'h77);
    scan_addr = 7'h15; #1;
    check("R9 scan row1 col5", scan_char, 8'h77);
    scan_addr = 7'h7F; #1;
    check("R9 scan last cell", scan_char, 8'h5A);
    @(negedge clk);

    // R10: writes to address 3 are inert
    bus_write(2'd3, 8'hFF);
    bus_read(2'd2, rd); check("R10 cursor after addr3 write", rd, 8'h16);
    bus_read(2'd1, rd); check("R10 control after addr3 write", rd, 8'h01);
    scan_addr = 7'h16; #1;
    rd = scan_char;
    bus_write(2'd2, 8'h15);
    bus_read(2'd0, rd); check("R10 cell kept after addr3 write", rd, 8'h77);

    // R6 / R7: blank the buffer
    bus_write(2'd2, 8'h30);
    bus_write(2'd1, 8'h03);      // advance on, start blank
    bus_read(2'd1, rd); check("R6 busy bit during blank", rd, 8'h03);
    bus_write(2'd0, 8'h99);      // dropped
    bus_read(2'd2, rd); check("R7 no advance during blank", rd, 8'h30);
    repeat (130) @(negedge clk);
    bus_read(2'd1, rd); check("R6 busy cleared after blank", rd, 8'h01);
    bus_read(2'd0, rd); check("R7 dropped write left no cell", rd, 8'h20);
    mism = 0;
    for (int c = 0; c < 128; c++) begin
      scan_addr = 7'(c); #1;
      if (scan_char !== 8'h20) mism++;
    end
    check("R6 all cells are 0x20", 8'(mism), 8'h00);
    @(negedge clk);

    // R2: writes work again after blank
    bus_write(2'd0, 8'h61);
    bus_write(2'd2, 8'h30);
    bus_read(2'd0, rd); check("R2 store after blank", rd, 8'h61);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule